// File: doc/BRIEF.md
# Full-Step Stepper Motor Sequencer

This block drives a two-phase stepper motor with centre-tapped windings. It has an 8-bit coil port. Each of the four low bits, when high, switches on an external transistor that grounds one winding terminal. The four high bits stay at zero. The pattern always has two terminals on. A step moves to the next pattern in a fixed four-entry cycle. The motor turns 1.8 degrees per step, so 200 steps make one full turn.

A step can be requested in two ways:
- A single-step strobe, which produces one step.
- A move command, which latches a step count. The block then issues that many steps, paced by a programmable delay, and pulses a done flag when the move is complete.

After every step, a delay counter holds off the next step so that the winding current can settle. The direction input is sampled at each step.

Top module: `stepper_seq`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `coil_port` is 8'h03 and `move_done` is low.
- R2: `coil_port[7:4]` is always zero. The low nibble always has exactly two bits set, and is one of 8'h03, 8'h06, 8'h0C, 8'h09.
- R3: With `dir_cw` = 1, a step follows the cycle 03 → 06 → 0C → 09 → 03. With `dir_cw` = 0, a step walks the same cycle backwards. `dir_cw` is sampled at each step, so consecutive patterns differ in exactly one bit turning off and one bit turning on.
- R4: The block is idle when no move is active and the delay count is zero. A `step_req` sampled high on a clock edge while idle advances the pattern, and the new pattern is visible after that edge.
- R5: Each step loads `delay_cycles` (D), as sampled at that step, into the delay counter. No further step occurs for the next D clock edges. A `step_req` arriving while the delay is running, or while a move is active, has no effect.
- R6: A `move_start` accepted while idle latches `move_steps` (N). The first step follows on the next edge, and the remaining steps follow at intervals of D+1 cycles, for exactly N steps.
- R7: After a move is accepted on edge 0, `move_done` is high for exactly one cycle, following edge N·(D+1)+1. No step occurs on that edge. A count of zero produces the done pulse after edge 1 and no step.
- R8: A `move_start` arriving while a move is active or the delay is running has no effect. When `move_start` and `step_req` arrive on the same idle edge, the move is taken and the single step is dropped.
- R9: A 200-step move in either direction returns the coil pattern to its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_req | input | 1 | Single-step request strobe |
| dir_cw | input | 1 | Direction: 1 clockwise, 0 counter-clockwise |
| delay_cycles | input | 16 | Settle delay in clocks after each step |
| move_start | input | 1 | Start a counted move |
| move_steps | input | 16 | Number of steps in a move |
| coil_port | output | 8 | Coil enables in the low nibble; the high nibble is zero |
| move_done | output | 1 | One-cycle pulse when a move finishes |

## Verification
The bench counts the cycle of every coil change during a move and compares it against 1+(j−1)(D+1). A design with an off-by-one delay reload would shift every step after the first. The bench also times the done pulse to the exact cycle and checks it for both a zero-step move and a full 200-step turn. A design that raised done on the last step, or stepped once more for a zero count, would miss that cycle.

The bench fires single-step strobes and extra move commands into a running delay or move. A design that failed to gate them would show an extra coil change or an early done. During every move, the bench holds `step_req` high through the done cycle, and that cycle must not produce a step.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

    localparam int COIL_W = 4;

    typedef logic [1:0] phase_t;

    // Cyclic order keeps one coil change per step
    function automatic logic [COIL_W-1:0] phase_code(input phase_t p);
        logic [COIL_W-1:0] c;
        case (p)
            2'd0:    c = 4'h3;
            2'd1:    c = 4'h6;
            2'd2:    c = 4'hC;
            default: c = 4'h9;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/stepseq_phase.sv
module stepseq_phase
    import stepseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              cw,
    output logic [COIL_W-1:0] coil
);

    typedef struct packed {
        phase_t            idx;
        logic [COIL_W-1:0] coil;
    } phase_s;

    phase_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (adv) begin
            s_d.idx = cw ? (s_q.idx + 2'd1) : (s_q.idx - 2'd1);
        end
        s_d.coil = phase_code(s_d.idx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.idx  <= 2'd0;
            s_q.coil <= phase_code(2'd0);
        end else begin
            s_q <= s_d;
        end
    end

    assign coil = s_q.coil;

endmodule

// File: rtl/stepseq_ctrl.sv
module stepseq_ctrl #(
    parameter int DELAY_W = 16,
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_req,
    input  logic               move_start,
    input  logic [COUNT_W-1:0] move_steps,
    input  logic [DELAY_W-1:0] delay_cycles,
    output logic               adv,
    output logic               done,
    output logic [DELAY_W-1:0] cnt_o
);

    localparam logic [DELAY_W-1:0] CNT_ONE = DELAY_W'(1);
    localparam logic [COUNT_W-1:0] REM_ONE = COUNT_W'(1);

    typedef struct packed {
        logic [DELAY_W-1:0] cnt;
        logic [COUNT_W-1:0] remain;
        logic               moving;
        logic               done;
    } ctrl_s;

    ctrl_s s_d, s_q;
    logic  adv_d;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        adv_d    = 1'b0;
        if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CNT_ONE;
        end else if (s_q.moving) begin
            if (s_q.remain != '0) begin
                adv_d      = 1'b1;
                s_d.remain = s_q.remain - REM_ONE;
                s_d.cnt    = delay_cycles;
            end else begin
                s_d.moving = 1'b0;
                s_d.done   = 1'b1;
            end
        end else if (move_start) begin
            s_d.moving = 1'b1;
            s_d.remain = move_steps;
        end else if (step_req) begin
            adv_d   = 1'b1;
            s_d.cnt = delay_cycles;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign adv   = adv_d;
    assign done  = s_q.done;
    assign cnt_o = s_q.cnt;

endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
    import stepseq_pkg::*;
#(
    parameter int DELAY_W = 16,
    parameter int COUNT_W = 16,
    parameter int PORT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_req,
    input  logic               dir_cw,
    input  logic [DELAY_W-1:0] delay_cycles,
    input  logic               move_start,
    input  logic [COUNT_W-1:0] move_steps,
    output logic [PORT_W-1:0]  coil_port,
    output logic               move_done
);

    logic              adv;
    logic [COIL_W-1:0] coil;
    logic [DELAY_W-1:0] delay_cnt;

    stepseq_ctrl #(
        .DELAY_W (DELAY_W),
        .COUNT_W (COUNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_req     (step_req),
        .move_start   (move_start),
        .move_steps   (move_steps),
        .delay_cycles (delay_cycles),
        .adv          (adv),
        .done         (move_done),
        .cnt_o        (delay_cnt)
    );

    stepseq_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .cw    (dir_cw),
        .coil  (coil)
    );

    assign coil_port[COIL_W-1:0] = coil;

    generate
        for (genvar gi = COIL_W; gi < PORT_W; gi++) begin : g_hi_zero
            assign coil_port[gi] = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/stepper_seq_chk.sv
module stepper_seq_chk #(
    parameter int PORT_W  = 8,
    parameter int DELAY_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PORT_W-1:0]  coil_port,
    input logic               move_done,
    input logic [DELAY_W-1:0] delay_cnt
);

    // R2
    hi_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coil_port[PORT_W-1:4] == '0);

    // R2
    two_coils_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(coil_port[3:0]) == 2);

    // R3
    one_coil_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coil_port != $past(coil_port)) |->
            $countones(coil_port ^ $past(coil_port)) == 2);

    // R5
    step_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coil_port != $past(coil_port)) |-> ($past(delay_cnt) == '0));

    // R7
    done_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        move_done |-> $stable(coil_port));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        move_done |-> (delay_cnt == '0));

endmodule

bind stepper_seq stepper_seq_chk #(
    .PORT_W  (PORT_W),
    .DELAY_W (DELAY_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .coil_port (coil_port),
    .move_done (move_done),
    .delay_cnt (delay_cnt)
);

// File: tb/stepper_seq_tb.sv
module stepper_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_req;
    logic        dir_cw;
    logic [15:0] delay_cycles;
    logic        move_start;
    logic [15:0] move_steps;
    logic [7:0]  coil_port;
    logic        move_done;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [7:0] cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    stepper_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_req     (step_req),
        .dir_cw       (dir_cw),
        .delay_cycles (delay_cycles),
        .move_start   (move_start),
        .move_steps   (move_steps),
        .coil_port    (coil_port),
        .move_done    (move_done)
    );

    function automatic logic [7:0] next_code(input logic [7:0] c, input logic cw);
        logic [7:0] f, b;
        case (c)
            8'h03:   begin f = 8'h06; b = 8'h09; end
            8'h06:   begin f = 8'h0C; b = 8'h03; end
            8'h0C:   begin f = 8'h09; b = 8'h06; end
            default: begin f = 8'h03; b = 8'h0C; end
        endcase
        return cw ? f : b;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic single_step(input logic cw, input int d);
        step_req = 1'b1; dir_cw = cw; delay_cycles = 16'(d);
        @(negedge clk);
        step_req = 1'b0;
        check(coil_port == next_code(cur, cw), "R4 single step pattern",
              coil_port, next_code(cur, cw));
        cur = next_code(cur, cw);
        if (d >= 1) begin
            step_req = 1'b1;
            @(negedge clk);
            step_req = 1'b0;
            check(coil_port == cur, "R5 step_req during delay ignored", coil_port, cur);
            repeat (d - 1) @(negedge clk);
        end
    endtask

    task automatic run_move(input int n, input int d, input logic cw,
                            input bit hold_req, input bit mid_start);
        int steps = 0;
        int done_k = -1;
        bit pos_bad = 1'b0;
        bit seq_bad = 1'b0;
        int limit = n * (d + 1) + 10;
        logic [7:0] prev = cur;
        logic [7:0] start = cur;
        logic [7:0] exp_end = cur;
        for (int i = 0; i < n % 4; i++) exp_end = next_code(exp_end, cw);
        move_start = 1'b1; move_steps = 16'(n); delay_cycles = 16'(d);
        dir_cw = cw; step_req = hold_req;
        @(negedge clk);
        move_start = 1'b0;
        for (int k = 0; k < limit; k++) begin
            if (coil_port != prev) begin
                steps++;
                if (k != 1 + (steps - 1) * (d + 1)) pos_bad = 1'b1;
                if (coil_port != next_code(prev, cw)) seq_bad = 1'b1;
                prev = coil_port;
            end
            if (move_done) begin
                done_k = k;
                step_req = 1'b0;
                break;
            end
            move_start = (mid_start && k == 2);
            move_steps = 16'd7;
            @(negedge clk);
            move_start = 1'b0;
        end
        step_req = 1'b0;
        check(steps == n, "R6 step count of move", steps, n);
        check(!pos_bad, "R6 step spacing D+1", pos_bad, 0);
        check(!seq_bad, "R3 direction order", seq_bad, 0);
        check(done_k == n * (d + 1) + 1, "R7 done cycle", done_k, n * (d + 1) + 1);
        check(coil_port == exp_end, "R3 final pattern", coil_port, exp_end);
        @(negedge clk);
        check(!move_done && coil_port == prev, "R7 done one cycle, no step after",
              move_done, 0);
        if (n == 200) check(coil_port == start, "R9 full turn returns", coil_port, start);
        cur = coil_port;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; step_req = 1'b0; dir_cw = 1'b1;
        delay_cycles = '0; move_start = 1'b0; move_steps = '0;
        repeat (3) @(negedge clk);
        check(coil_port == 8'h03 && !move_done, "R1 reset pattern", coil_port, 8'h03);
        rst_n = 1'b1;
        @(negedge clk);
        check(coil_port == 8'h03 && !move_done, "R1 after release", coil_port, 8'h03);
        check(coil_port[7:4] == 4'h0, "R2 upper nibble zero", coil_port[7:4], 0);
        cur = 8'h03;

        // directed single steps, both directions, several delays
        single_step(1'b1, 0);
        single_step(1'b1, 3);
        single_step(1'b0, 1);
        single_step(1'b0, 4);

        // R8: move_start during a running delay is ignored
        step_req = 1'b1; dir_cw = 1'b1; delay_cycles = 16'd5;
        @(negedge clk);
        step_req = 1'b0;
        cur = next_code(cur, 1'b1);
        move_start = 1'b1; move_steps = 16'd3;
        @(negedge clk);
        move_start = 1'b0;
        begin
            bit bad = 1'b0;
            for (int i = 0; i < 8; i++) begin
                if (move_done || coil_port != cur) bad = 1'b1;
                @(negedge clk);
            end
            check(!bad, "R8 move_start during delay ignored", bad, 0);
        end

        // directed moves: zero count, one step, simultaneous request, mid start
        run_move(0, 2, 1'b1, 1'b0, 1'b0);
        run_move(1, 0, 1'b0, 1'b0, 1'b0);
        run_move(5, 2, 1'b1, 1'b1, 1'b0);  // R8 move wins over step_req
        run_move(6, 3, 1'b0, 1'b0, 1'b1);  // R8 second move_start ignored
        run_move(200, 2, 1'b1, 1'b0, 1'b0);
        run_move(200, 0, 1'b0, 1'b1, 1'b0);

        // random moves and steps
        for (int r = 0; r < 24; r++) begin
            if ($urandom % 3 == 0)
                single_step(1'($urandom % 2), int'($urandom % 5));
            else
                run_move(int'($urandom % 24), int'($urandom % 6), 1'($urandom % 2),
                         1'($urandom % 2), 1'($urandom % 2));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule